// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block resolves short relative branches for an 8-bit processor core. For each branch it is handed, it decides whether the branch is taken and produces the next program counter. It receives the low four bits of the branch opcode (`cond_sel`) and a flag (`alt_prefix`) that marks the alternate-condition prefix. It also receives the seven condition-code bits, the level of an external interrupt line, the address of the branch's first byte and a signed 8-bit displacement.

The decode stage presents one branch per cycle with `valid_in` high. One clock later the block returns its verdict on `out_valid`, `taken`, `illegal` and `next_pc`. When `valid_in` is low, the result registers hold their previous values. The result feeds the fetch unit as its redirect address. Selector values are paired: an odd selector tests a condition and the even selector below it tests the opposite condition.

The sequential address is the byte after the branch: `pc_cur` + 2 for an unprefixed branch and `pc_cur` + 3 for a prefixed one. The jump target is the sequential address plus the sign-extended displacement. All address arithmetic wraps modulo 2^24.

Top module: `br_eval_top`

## Requirements
- R1: While `rst` is high, and after it, until the first accepted branch, `out_valid`, `taken` and `illegal` are 0 and `next_pc` is 0.
- R2: A branch presented with `valid_in` high gives `out_valid` high exactly one cycle later. A cycle with `valid_in` low gives `out_valid` low one cycle later, and `taken`, `illegal` and `next_pc` keep their values.
- R3: With no prefix, selector 0 is always taken and selector 1 is never taken.
- R4: With no prefix, selectors 2/3 branch on (C=0 and Z=0) / (C=1 or Z=1). Selectors 4/5 branch on C=0 / C=1. Selectors 6/7 branch on Z=0 / Z=1.
- R5: With no prefix, selectors 8/9 branch on V=0 / V=1, and selectors A/B branch on N=0 / N=1.
- R6: With no prefix, selectors C/D branch on (Z=0 and N=V) / (Z=1 or N≠V). Selectors E/F branch on N=V / N≠V.
- R7: With the prefix, selectors 8/9 branch on H=0 / H=1.
- R8: With the prefix, selectors C/D branch on the interrupt mask being clear / set. The mask counts as set only when I1=1 and I0=1.
- R9: With the prefix, selectors E/F branch on the interrupt line being low / high.
- R10: With the prefix, selectors 0–7, A and B are undefined. They set `illegal`, leave `taken` low and give the sequential address.
- R11: A taken branch gives `next_pc` = `pc_cur` + length + sign-extended `disp`, modulo 2^24. The length is 2 without the prefix and 3 with it.
- R12: A branch that is not taken gives `next_pc` = `pc_cur` + length, modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | A branch is presented this cycle |
| alt_prefix | input | 1 | Alternate-condition prefix present |
| cond_sel | input | 4 | Low nibble of the branch opcode |
| ccr_v | input | 1 | Overflow flag |
| ccr_i1 | input | 1 | Interrupt mask bit 1 |
| ccr_h | input | 1 | Half-carry flag |
| ccr_i0 | input | 1 | Interrupt mask bit 0 |
| ccr_n | input | 1 | Negative flag |
| ccr_z | input | 1 | Zero flag |
| ccr_c | input | 1 | Carry flag |
| irq_level | input | 1 | External interrupt line level |
| pc_cur | input | 24 | Address of the branch's first byte |
| disp | input | 8 | Signed displacement |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Undefined prefixed selector |
| next_pc | output | 24 | Next program counter |

## Verification
The assertions assume that all inputs are known whenever `valid_in` is high. They also assume that `valid_in` is low while `rst` is high, so that the latency and hold properties only see branches that the registers actually accepted. The stimulus drives inputs only on the falling clock edge and keeps `valid_in` low during reset. It sweeps all 32 prefix and selector combinations against several flag sets, places address-wrap cases near both ends of the space, and inserts idle cycles between random branches.

// File: rtl/br_pkg.sv
package br_pkg;

    // Condition-code bits delivered by the flag logic
    typedef struct packed {
        logic v;
        logic i1;
        logic h;
        logic i0;
        logic n;
        logic z;
        logic c;
    } ccr_t;

    // Base test selected by the upper three selector bits; the
    // lowest selector bit picks the test itself (1) or its opposite (0)
    typedef enum logic [3:0] {
        TST_FALSE = 4'd0,
        TST_CZ    = 4'd1,
        TST_C     = 4'd2,
        TST_Z     = 4'd3,
        TST_V     = 4'd4,
        TST_N     = 4'd5,
        TST_ZNV   = 4'd6,
        TST_NV    = 4'd7,
        TST_H     = 4'd8,
        TST_MASK  = 4'd9,
        TST_IRQ   = 4'd10
    } test_e;

    typedef struct packed {
        test_e test;
        logic  invert;
        logic  bad;
    } sel_t;

    // Interrupt mask is considered set only at the highest level
    function automatic logic mask_at_top(input ccr_t f);
        return f.i1 & f.i0;
    endfunction

    // Signed-compare helper: N differs from V
    function automatic logic sign_mismatch(input ccr_t f);
        return f.n ^ f.v;
    endfunction

endpackage

// File: rtl/br_cond_decode.sv
module br_cond_decode
    import br_pkg::*;
(
    input  logic       alt_prefix,
    input  logic [3:0] cond_sel,
    output sel_t       sel
);
    logic [2:0] pair;

    assign pair = cond_sel[3:1];

    always_comb begin
        sel.invert = ~cond_sel[0];
        sel.bad    = 1'b0;
        sel.test   = TST_FALSE;
        if (!alt_prefix) begin
            case (pair)
                3'd0:    sel.test = TST_FALSE;
                3'd1:    sel.test = TST_CZ;
                3'd2:    sel.test = TST_C;
                3'd3:    sel.test = TST_Z;
                3'd4:    sel.test = TST_V;
                3'd5:    sel.test = TST_N;
                3'd6:    sel.test = TST_ZNV;
                default: sel.test = TST_NV;
            endcase
        end else begin
            case (pair)
                3'd4:    sel.test = TST_H;
                3'd6:    sel.test = TST_MASK;
                3'd7:    sel.test = TST_IRQ;
                default: sel.bad  = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/br_cond_test.sv
module br_cond_test
    import br_pkg::*;
(
    input  test_e test,
    input  ccr_t  flags,
    input  logic  irq_level,
    output logic  base
);
    always_comb begin
        case (test)
            TST_FALSE: base = 1'b0;
            TST_CZ:    base = flags.c | flags.z;
            TST_C:     base = flags.c;
            TST_Z:     base = flags.z;
            TST_V:     base = flags.v;
            TST_N:     base = flags.n;
            TST_ZNV:   base = flags.z | sign_mismatch(flags);
            TST_NV:    base = sign_mismatch(flags);
            TST_H:     base = flags.h;
            TST_MASK:  base = mask_at_top(flags);
            TST_IRQ:   base = irq_level;
            default:   base = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target.sv
module br_target #(
    parameter int PC_W      = 24,
    parameter int DISP_W    = 8,
    parameter int LEN_PLAIN = 2,
    parameter int LEN_PREF  = 3
) (
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [DISP_W-1:0] disp,
    input  logic              alt_prefix,
    output logic [PC_W-1:0]   seq_pc,
    output logic [PC_W-1:0]   jump_pc
);
    localparam int EXT_W = PC_W - DISP_W;
    localparam logic [PC_W-1:0] STEP_PLAIN = PC_W'(LEN_PLAIN);
    localparam logic [PC_W-1:0] STEP_PREF  = PC_W'(LEN_PREF);

    logic [PC_W-1:0] disp_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[PC_W-1:0];
        end
    endgenerate

    assign seq_pc  = pc_cur + (alt_prefix ? STEP_PREF : STEP_PLAIN);
    assign jump_pc = seq_pc + disp_ext;
endmodule

// File: rtl/br_eval_top.sv
module br_eval_top
    import br_pkg::*;
#(
    parameter int PC_W      = 24,
    parameter int DISP_W    = 8,
    parameter int LEN_PLAIN = 2,
    parameter int LEN_PREF  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic              alt_prefix,
    input  logic [3:0]        cond_sel,
    input  logic              ccr_v,
    input  logic              ccr_i1,
    input  logic              ccr_h,
    input  logic              ccr_i0,
    input  logic              ccr_n,
    input  logic              ccr_z,
    input  logic              ccr_c,
    input  logic              irq_level,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [DISP_W-1:0] disp,
    output logic              out_valid,
    output logic              taken,
    output logic              illegal,
    output logic [PC_W-1:0]   next_pc
);
    ccr_t            flags;
    sel_t            sel;
    logic            base;
    logic            take_c;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] jump_pc;
    logic [PC_W-1:0] next_c;

    assign flags = '{v: ccr_v, i1: ccr_i1, h: ccr_h, i0: ccr_i0,
                     n: ccr_n, z: ccr_z, c: ccr_c};

    br_cond_decode u_decode (
        .alt_prefix (alt_prefix),
        .cond_sel   (cond_sel),
        .sel        (sel)
    );

    br_cond_test u_test (
        .test      (sel.test),
        .flags     (flags),
        .irq_level (irq_level),
        .base      (base)
    );

    br_target #(
        .PC_W      (PC_W),
        .DISP_W    (DISP_W),
        .LEN_PLAIN (LEN_PLAIN),
        .LEN_PREF  (LEN_PREF)
    ) u_target (
        .pc_cur     (pc_cur),
        .disp       (disp),
        .alt_prefix (alt_prefix),
        .seq_pc     (seq_pc),
        .jump_pc    (jump_pc)
    );

    assign take_c = ~sel.bad & (base ^ sel.invert);
    assign next_c = take_c ? jump_pc : seq_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            illegal   <= 1'b0;
            next_pc   <= '0;
        end else begin
            out_valid <= valid_in;
            if (valid_in) begin
                taken   <= take_c;
                illegal <= sel.bad;
                next_pc <= next_c;
            end
        end
    end
endmodule

// File: rtl/br_eval_chk.sv
module br_eval_chk #(
    parameter int PC_W      = 24,
    parameter int LEN_PLAIN = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            valid_in,
    input logic            alt_prefix,
    input logic [3:0]      cond_sel,
    input logic [PC_W-1:0] pc_cur,
    input logic            out_valid,
    input logic            taken,
    input logic            illegal,
    input logic [PC_W-1:0] next_pc
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> (!out_valid && $stable(next_pc) && $stable(taken) && $stable(illegal)));

    assert_always_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !alt_prefix && cond_sel == 4'h0) |=> taken);

    assert_never_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !alt_prefix && cond_sel == 4'h1) |=> !taken);

    assert_illegal_not_taken_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |-> !taken);

    assert_plain_never_illegal_R10: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !alt_prefix) |=> !illegal);

    assert_never_sequential_R12: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !alt_prefix && cond_sel == 4'h1) |=>
        (next_pc == PC_W'($past(pc_cur) + PC_W'(LEN_PLAIN))));
endmodule

bind br_eval_top br_eval_chk #(
    .PC_W      (PC_W),
    .LEN_PLAIN (LEN_PLAIN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_in   (valid_in),
    .alt_prefix (alt_prefix),
    .cond_sel   (cond_sel),
    .pc_cur     (pc_cur),
    .out_valid  (out_valid),
    .taken      (taken),
    .illegal    (illegal),
    .next_pc    (next_pc)
);

// File: tb/br_eval_top_tb.sv
module br_eval_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_in;
    logic        alt_prefix;
    logic [3:0]  cond_sel;
    logic        ccr_v, ccr_i1, ccr_h, ccr_i0, ccr_n, ccr_z, ccr_c;
    logic        irq_level;
    logic [23:0] pc_cur;
    logic [7:0]  disp;
    logic        out_valid, taken, illegal;
    logic [23:0] next_pc;

    int checks = 0;
    int failures = 0;

    // expected state of the outputs after the next rising edge
    bit          e_valid, e_taken, e_illegal;
    logic [23:0] e_pc;
    string       e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    br_eval_top u_dut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .alt_prefix(alt_prefix),
        .cond_sel(cond_sel), .ccr_v(ccr_v), .ccr_i1(ccr_i1), .ccr_h(ccr_h),
        .ccr_i0(ccr_i0), .ccr_n(ccr_n), .ccr_z(ccr_z), .ccr_c(ccr_c),
        .irq_level(irq_level), .pc_cur(pc_cur), .disp(disp),
        .out_valid(out_valid), .taken(taken), .illegal(illegal), .next_pc(next_pc)
    );

    task automatic compare();
        checks++;
        if (out_valid !== e_valid || taken !== e_taken ||
            illegal !== e_illegal || next_pc !== e_pc) begin
            failures++;
            $display("FAIL %s: got v=%0b t=%0b i=%0b pc=%06h, expected v=%0b t=%0b i=%0b pc=%06h",
                     e_tag, out_valid, taken, illegal, next_pc,
                     e_valid, e_taken, e_illegal, e_pc);
        end
    endtask

    // behavioural reference: verdict per prefix/selector combination
    task automatic predict(input bit pf, input bit [3:0] nb, input bit v, input bit i1,
                           input bit h, input bit i0, input bit n, input bit z,
                           input bit c, input bit irq, input bit [23:0] pc,
                           input bit [7:0] d);
        bit tk = 0;
        bit il = 0;
        string tg;
        longint seq;
        longint tgt;
        case ({pf, nb})
            5'h00: begin tk = 1;              tg = "R3"; end
            5'h01: begin tk = 0;              tg = "R3"; end
            5'h02: begin tk = !c && !z;       tg = "R4"; end
            5'h03: begin tk = c || z;         tg = "R4"; end
            5'h04: begin tk = !c;             tg = "R4"; end
            5'h05: begin tk = c;              tg = "R4"; end
            5'h06: begin tk = !z;             tg = "R4"; end
            5'h07: begin tk = z;              tg = "R4"; end
            5'h08: begin tk = !v;             tg = "R5"; end
            5'h09: begin tk = v;              tg = "R5"; end
            5'h0A: begin tk = !n;             tg = "R5"; end
            5'h0B: begin tk = n;              tg = "R5"; end
            5'h0C: begin tk = !z && (n == v); tg = "R6"; end
            5'h0D: begin tk = z || (n != v);  tg = "R6"; end
            5'h0E: begin tk = (n == v);       tg = "R6"; end
            5'h0F: begin tk = (n != v);       tg = "R6"; end
            5'h18: begin tk = !h;             tg = "R7"; end
            5'h19: begin tk = h;              tg = "R7"; end
            5'h1C: begin tk = !(i1 && i0);    tg = "R8"; end
            5'h1D: begin tk = i1 && i0;       tg = "R8"; end
            5'h1E: begin tk = !irq;           tg = "R9"; end
            5'h1F: begin tk = irq;            tg = "R9"; end
            default: begin tk = 0; il = 1;    tg = "R10"; end
        endcase
        seq = longint'(pc) + (pf ? 3 : 2);
        tgt = seq + longint'($signed(d));
        e_valid   = 1;
        e_taken   = tk;
        e_illegal = il;
        e_pc      = tk ? tgt[23:0] : seq[23:0];
        e_tag     = {tg, tk ? "/R11" : "/R12", "/R2"};
    endtask

    task automatic step(input bit vin, input bit pf, input bit [3:0] nb,
                        input bit [6:0] fl, input bit irq,
                        input bit [23:0] pc, input bit [7:0] d);
        @(negedge clk);
        compare();
        valid_in   = vin;
        alt_prefix = pf;
        cond_sel   = nb;
        {ccr_v, ccr_i1, ccr_h, ccr_i0, ccr_n, ccr_z, ccr_c} = fl;
        irq_level  = irq;
        pc_cur     = pc;
        disp       = d;
        if (vin) predict(pf, nb, fl[6], fl[5], fl[4], fl[3], fl[2], fl[1], fl[0], irq, pc, d);
        else begin
            e_valid = 0;
            e_tag   = "R2 idle hold";
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; valid_in = 0; alt_prefix = 0; cond_sel = 0;
        {ccr_v, ccr_i1, ccr_h, ccr_i0, ccr_n, ccr_z, ccr_c} = '0;
        irq_level = 0; pc_cur = 24'h123456; disp = 8'h10;
        e_valid = 0; e_taken = 0; e_illegal = 0; e_pc = '0; e_tag = "R1 reset";
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();                       // R1 during reset
        rst = 0;
        e_tag = "R1 after reset";
        step(0, 0, 4'h0, 7'h00, 0, 24'h000100, 8'h05);

        // sweep every combination under several flag sets (R3..R12)
        for (int f = 0; f < 128; f += 9) begin
            for (int k = 0; k < 32; k++) begin
                step(1, k[4], k[3:0], f[6:0], f[0] ^ f[3],
                     24'h004000 + 24'(k * 16), 8'(k * 11 - 100));
            end
        end

        // address wrap cases (R11, R12)
        step(1, 1, 4'hF, 7'h00, 1, 24'hFFFFFE, 8'h05);   // prefixed, taken, wraps up
        step(1, 0, 4'h0, 7'h00, 0, 24'h000001, 8'h80);   // always, -128 wraps down
        step(1, 0, 4'h1, 7'h00, 0, 24'hFFFFFF, 8'h7F);   // never, sequential wraps
        step(1, 1, 4'h3, 7'h7F, 1, 24'hFFFFFD, 8'h40);   // illegal (R10)
        step(0, 0, 4'h0, 7'h00, 0, 24'h000000, 8'h00);   // idle hold (R2)
        step(0, 1, 4'h9, 7'h7F, 1, 24'hABCDEF, 8'hFF);   // idle hold (R2)

        // mask levels for R8
        for (int m = 0; m < 4; m++) begin
            step(1, 1, 4'hC, {1'b0, m[1], 1'b0, m[0], 3'b000}, 0, 24'h200000, 8'hF0);
            step(1, 1, 4'hD, {1'b0, m[1], 1'b0, m[0], 3'b000}, 0, 24'h200000, 8'h0F);
        end

        // random traffic with idle gaps
        for (int r = 0; r < 3000; r++) begin
            bit [31:0] a = $urandom;
            bit [31:0] b = $urandom;
            step(a[0] | a[1], a[2], a[6:3], a[13:7], a[14], b[23:0], b[31:24]);
        end

        @(negedge clk);
        compare();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule